// File: doc/BRIEF.md
# Host Mailbox Byte Channel

This block links a host CPU to a system-management microcontroller through two 16-entry byte FIFOs. The host sees a 32-byte register window with three 32-bit registers: an interrupt register, a data register and a status register. A host write to the data register pushes one byte toward the microcontroller. A host read of the data register pops one byte that the microcontroller has sent. The microcontroller side is a plain byte stream. The transmit direction presents a head byte with a valid flag and pops on a take strobe. The receive direction accepts a byte on a push strobe.

Four FIFO conditions are tracked: transmit empty, transmit not full, receive not empty and receive overflow. Each condition has a latched request bit and a mask bit. A single interrupt line is raised when an enabled request is pending. Request bits are write-one-to-clear, either through the status register or through the low nibble of the interrupt register. The host acknowledges everything pending by writing back the status value it has just read.

Top module: `mbox_regif`

## Requirements
- R1: After reset the interrupt register reads 0x00, the status register reads 0x03, a data read returns 0, the interrupt output is low and the transmit valid flag is low.
- R2: The register at byte offset 0x00 is the interrupt register, 0x04 is the data register and 0x08 is the status register. Every other offset in the 32-byte window reads 0. Unused register bits read 0.
- R3: A write to the data register queues bits 15:8 of the write data for the microcontroller. Bytes leave on the transmit byte port in the order they were written, and bits 31:16 and 7:0 of the write are ignored.
- R4: The transmit FIFO holds 16 bytes. A data write while 16 bytes are held is dropped, and after 16 takes the transmit valid flag is low.
- R5: A data-register read returns the oldest received byte in bits 15:8 with all other bits 0, and removes that byte. A read while the receive FIFO is empty returns 0 and changes nothing.
- R6: A push from the microcontroller while 16 received bytes are held drops that byte and sets status bit 3 and request bit 3. Both stay set until a 1 is written to bit 3.
- R7: Request bits 0, 1 and 2 are set one cycle after transmit-empty, transmit-not-full and receive-not-empty respectively go from false to true. A condition that simply stays true does not set its bit again.
- R8: Writing 1 to any of bits 3:0 of the status register or of the interrupt register clears that request bit. Writing 0 leaves it unchanged. A set and a clear in the same cycle leave the bit set.
- R9: Interrupt-register bits 7:4 are mask bits for requests 0 to 3. They are loaded by writes to the interrupt register and read back there. The interrupt output is high exactly when some request bit and its mask bit are both 1.
- R10: Status bits 0, 1 and 2 show, live, transmit FIFO empty, transmit FIFO not full and receive FIFO not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access strobe, one cycle per access |
| hostWr | input | 1 | 1 for write, 0 for read |
| hostAddr | input | 5 | Byte offset within the register window |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, valid while hostSel is high for a read |
| irq | output | 1 | Interrupt to the host |
| txByte | output | 8 | Head byte of the transmit FIFO |
| txValid | output | 1 | Transmit FIFO holds a byte |
| txTake | input | 1 | Microcontroller removes the head byte |
| rxByte | input | 8 | Byte from the microcontroller |
| rxPush | input | 1 | Microcontroller delivers rxByte |

## Verification
The hardest case to reach is a request being set and cleared in the same clock. The rising edge of a condition is only registered one cycle after the FIFO changes, so the host clear has to be placed exactly one cycle after the microcontroller push. The bench does this with a hand-timed sequence: it pushes into an empty receive FIFO and, on the very next cycle, writes a clear of bit 2 to the status register. It then expects the request to survive. Overflow comes second: the bench fills the receive FIFO to 16 entries, pushes a 17th byte, and then drains the FIFO against its scoreboard to show that the extra byte never arrives.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int NSRC   = 4;

  // word indices inside the register window (byte offset / 4)
  localparam logic [2:0] WIDX_INTR = 3'd0;
  localparam logic [2:0] WIDX_DATA = 3'd1;
  localparam logic [2:0] WIDX_STAT = 3'd2;

  // condition / request bit positions
  localparam int SRC_TXE  = 0;
  localparam int SRC_TXNF = 1;
  localparam int SRC_RXNE = 2;
  localparam int SRC_RXO  = 3;

  typedef struct packed {
    logic              txPush;
    logic [BYTE_W-1:0] txData;
    logic              rxPop;
    logic [NSRC-1:0]   reqClr;
  } mbox_strobe_t;
endpackage

// File: rtl/mbox_fifo.sv
`timescale 1ns/1ps
module mbox_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  assert_full_push_dropped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> full);
  assert_empty_pop_harmless_R5: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/mbox_dp.sv
`timescale 1ns/1ps
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbox_strobe_t      strb,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  input  logic              txTake,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxPush,
  output logic [BYTE_W-1:0] rxHead,
  output logic [NSRC-1:0]   liveCond,
  output logic [NSRC-1:0]   req
);
  logic txEmpty, txFull, rxEmpty, rxFull;
  logic ovfFlag, ovfEvent;
  logic [2:0]      prevCond;
  logic [NSRC-1:0] setEv;

  mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(strb.txPush), .din(strb.txData),
    .pop(txTake), .dout(txByte),
    .empty(txEmpty), .full(txFull)
  );

  mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(rxPush), .din(rxByte),
    .pop(strb.rxPop), .dout(rxHead),
    .empty(rxEmpty), .full(rxFull)
  );

  assign txValid  = !txEmpty;
  assign ovfEvent = rxPush && rxFull;

  always_comb begin
    liveCond[SRC_TXE]  = txEmpty;
    liveCond[SRC_TXNF] = !txFull;
    liveCond[SRC_RXNE] = !rxEmpty;
    liveCond[SRC_RXO]  = ovfFlag;
  end

  // rising edges of the three level conditions, plus the overflow event
  always_comb begin
    setEv[2:0]     = liveCond[2:0] & ~prevCond;
    setEv[SRC_RXO] = ovfEvent;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCond <= 3'b011;   // tx empty and not full after reset
      req      <= '0;
      ovfFlag  <= 1'b0;
    end else begin
      prevCond <= liveCond[2:0];
      req      <= (req & ~strb.reqClr) | setEv;
      ovfFlag  <= ovfEvent | (ovfFlag & ~strb.reqClr[SRC_RXO]);
    end
  end

  assert_ovf_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull) |=> (ovfFlag && req[SRC_RXO]));
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strb.reqClr[SRC_RXO]) |=> ovfFlag);
  assert_rx_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull && !strb.rxPop) |=> !rxEmpty);
  assert_rxne_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(liveCond[SRC_RXNE])) |-> ##0 1'b1 ##1 req[SRC_RXNE]);
endmodule

// File: rtl/mbox_ctrl.sv
`timescale 1ns/1ps
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [REG_W-1:0]  hostWdata,
  output logic [REG_W-1:0]  hostRdata,
  output logic              irq,
  input  logic [NSRC-1:0]   liveCond,
  input  logic [NSRC-1:0]   req,
  input  logic [BYTE_W-1:0] rxHead,
  output mbox_strobe_t      strb
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [NSRC-1:0]   mask;
  logic              aligned;
  logic [WIDX_W-1:0] wordIdx;
  logic              wrIntr, wrData, wrStat, rdData;
  logic              unusedWdata;

  assign aligned     = (hostAddr[1:0] == 2'b00);
  assign wordIdx     = hostAddr[ADDR_W-1:2];
  assign unusedWdata = ^hostWdata[REG_W-1:16];

  assign wrIntr = hostSel && hostWr  && aligned && (wordIdx == WIDX_W'(WIDX_INTR));
  assign wrData = hostSel && hostWr  && aligned && (wordIdx == WIDX_W'(WIDX_DATA));
  assign wrStat = hostSel && hostWr  && aligned && (wordIdx == WIDX_W'(WIDX_STAT));
  assign rdData = hostSel && !hostWr && aligned && (wordIdx == WIDX_W'(WIDX_DATA));

  always_comb begin
    strb.txPush = wrData;
    strb.txData = hostWdata[15:8];
    strb.rxPop  = rdData && liveCond[SRC_RXNE];
    strb.reqClr = (wrIntr || wrStat) ? hostWdata[NSRC-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       mask <= '0;
    else if (wrIntr) mask <= hostWdata[2*NSRC-1:NSRC];
  end

  assign irq = |(req & mask);

  always_comb begin
    hostRdata = '0;
    if (aligned) begin
      if (wordIdx == WIDX_W'(WIDX_INTR)) begin
        hostRdata[2*NSRC-1:0] = {mask, req};
      end else if (wordIdx == WIDX_W'(WIDX_DATA)) begin
        hostRdata[15:8] = liveCond[SRC_RXNE] ? rxHead : '0;
      end else if (wordIdx == WIDX_W'(WIDX_STAT)) begin
        hostRdata[NSRC-1:0] = liveCond;
      end
    end
  end

  assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrIntr |=> (mask == $past(hostWdata[2*NSRC-1:NSRC])));
  assert_no_req_no_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (req == '0) |-> !irq);
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.txPush, strb.rxPop, wrIntr, wrStat}));
endmodule

// File: rtl/mbox_regif.sv
`timescale 1ns/1ps
module mbox_regif
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              irq,
  output logic [7:0]        txByte,
  output logic              txValid,
  input  logic              txTake,
  input  logic [7:0]        rxByte,
  input  logic              rxPush
);
  mbox_strobe_t      strb;
  logic [NSRC-1:0]   liveCond;
  logic [NSRC-1:0]   req;
  logic [BYTE_W-1:0] rxHead;

  mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .irq(irq),
    .liveCond(liveCond), .req(req), .rxHead(rxHead), .strb(strb)
  );

  mbox_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txByte(txByte), .txValid(txValid), .txTake(txTake),
    .rxByte(rxByte), .rxPush(rxPush),
    .rxHead(rxHead), .liveCond(liveCond), .req(req)
  );

  assert_tx_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    txValid == !liveCond[SRC_TXE]);
endmodule

// File: tb/mbox_regif_test.sv
`timescale 1ns/1ps
module mbox_regif_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWr = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        irq, txValid;
  logic [7:0]  txByte;
  logic        txTake = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxPush = 1'b0;

  int nChk = 0, nBad = 0;
  bit done = 0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];

  mbox_regif uut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .irq(irq), .txByte(txByte), .txValid(txValid), .txTake(txTake),
    .rxByte(rxByte), .rxPush(rxPush)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  // monitor: compares bytes taken from the transmit side with the scoreboard (R3)
  initial forever begin
    @(negedge clk); #5;
    if (txValid && txTake) begin
      if (txQ.size() == 0) chk("R3 unexpected tx byte", {24'b0, txByte}, 32'hFFFF_FFFF);
      else chk("R3 tx byte order", {24'b0, txByte}, {24'b0, txQ.pop_front()});
    end
  end

  initial begin
    #(200000 * 20);
    nChk++; nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    hostSel = 1; hostWr = 1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 0; hostWr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    hostSel = 1; hostWr = 0; hostAddr = a;
    #5 d = hostRdata;
    @(negedge clk);
    hostSel = 0;
  endtask

  task automatic rdChk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  // driver: data-register write, expected byte into scoreboard if there is room
  task automatic hostSend(input logic [7:0] b);
    if (txQ.size() < 16) txQ.push_back(b);
    wr(5'h04, {16'hDEAD, b, 8'h5A});
  endtask

  task automatic hostRecv(input string tag);
    logic [31:0] exp;
    exp = (rxQ.size() != 0) ? {16'b0, rxQ.pop_front(), 8'b0} : 32'b0;
    rdChk(tag, 5'h04, exp);
  endtask

  task automatic mcuPush(input logic [7:0] b);
    if (rxQ.size() < 16) rxQ.push_back(b);
    @(negedge clk);
    rxPush = 1; rxByte = b;
    @(negedge clk);
    rxPush = 0;
  endtask

  task automatic mcuTake();
    @(negedge clk);
    txTake = 1;
    @(negedge clk);
    txTake = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    #5 chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 txValid", {31'b0, txValid}, 0);
    rdChk("R1 intr reg", 5'h00, 32'h0);
    rdChk("R1 status reg", 5'h08, 32'h3);
    rdChk("R1 data reg empty", 5'h04, 32'h0);
    // R2 unmapped and unaligned offsets
    rdChk("R2 offset 0x0C", 5'h0C, 32'h0);
    rdChk("R2 offset 0x1C", 5'h1C, 32'h0);
    rdChk("R2 offset 0x09", 5'h09, 32'h0);

    // R3 / R10 a few bytes through transmit
    hostSend(8'h11); hostSend(8'h22); hostSend(8'h33);
    rdChk("R10 status tx partly filled", 5'h08, 32'h2);
    repeat (3) mcuTake();
    idle(2);
    chk("R3 scoreboard drained", txQ.size(), 0);
    rdChk("R7 tx empty request only", 5'h00, 32'h01);
    wr(5'h08, 32'h1);
    rdChk("R8 clear via status", 5'h00, 32'h0);

    // R4 fill transmit past capacity
    for (int i = 0; i < 17; i++) hostSend(8'h40 + 8'(i));
    rdChk("R4 R10 status tx full", 5'h08, 32'h0);
    repeat (16) mcuTake();
    #5 chk("R4 seventeenth byte dropped", {31'b0, txValid}, 0);
    idle(2);
    rdChk("R7 tx not-full and empty requests", 5'h00, 32'h03);
    wr(5'h08, 32'h3);
    rdChk("R8 write back clears all", 5'h00, 32'h0);

    // R5 receive path
    mcuPush(8'hA5);
    idle(2);
    rdChk("R10 status rx not empty", 5'h08, 32'h7);
    rdChk("R7 rx request", 5'h00, 32'h04);
    hostRecv("R5 read head byte");
    rdChk("R10 status rx drained", 5'h08, 32'h3);
    hostRecv("R5 empty read is zero");
    wr(5'h08, 32'h4);
    rdChk("R8 clear rx request", 5'h00, 32'h0);

    // R9 masking
    wr(5'h00, 32'h40);
    rdChk("R9 mask readback", 5'h00, 32'h40);
    chk("R9 irq low without request", {31'b0, irq}, 0);
    mcuPush(8'h3C);
    idle(2);
    chk("R9 irq raised", {31'b0, irq}, 1);
    wr(5'h00, 32'h44);
    rdChk("R8 R9 clear via intr keeps mask", 5'h00, 32'h40);
    chk("R9 irq dropped", {31'b0, irq}, 0);
    hostRecv("R5 read second byte");
    idle(2);
    rdChk("R7 level does not re-set", 5'h00, 32'h40);

    // R6 receive overflow
    for (int i = 0; i < 17; i++) mcuPush(8'h80 + 8'(i));
    idle(2);
    rdChk("R6 status overflow", 5'h08, 32'hF);
    rdChk("R6 request bits", 5'h00, 32'h4C);
    chk("R6 irq", {31'b0, irq}, 1);
    for (int i = 0; i < 16; i++) hostRecv("R6 drain");
    hostRecv("R6 dropped byte absent");
    rdChk("R6 overflow sticky", 5'h08, 32'hB);
    wr(5'h08, 32'h8);
    rdChk("R6 overflow cleared", 5'h08, 32'h3);
    wr(5'h00, 32'h0F);
    rdChk("R8 intr W1C all, mask off", 5'h00, 32'h0);

    // R8 set wins over simultaneous clear
    @(negedge clk);
    rxQ.push_back(8'h77);
    rxPush = 1; rxByte = 8'h77;
    @(negedge clk);
    rxPush = 0;
    hostSel = 1; hostWr = 1; hostAddr = 5'h08; hostWdata = 32'h4;
    @(negedge clk);
    hostSel = 0; hostWr = 0;
    idle(1);
    rdChk("R8 set beats clear", 5'h00, 32'h04);
    hostRecv("R5 final byte");

    report();
  end
endmodule